// File: doc/BRIEF.md
# Debounced Input Change-of-State Detector

This block watches a small group of slow, asynchronous input pins and tells a processor when any of them has settled at a new level. Each pin first crosses into the system clock domain through a short flop chain. It is then sampled only when a slow sampling tick arrives; the tick is supplied from outside and is nominally about 25 µs apart. A new level is accepted only after two consecutive ticks have both seen it, so a pulse that lasts a single sample period is filtered out. Every accepted edge sets a sticky flag for that pin. Rising and falling edges are treated the same.

The processor reads a status byte. Its upper half holds the accepted levels and its lower half holds the change flags. A read strobe clears the flags on the same clock edge. If a transition is accepted on that same edge, its flag survives the read. A per-pin enable mask combines the flags into a single interrupt request. A separate, unlatched port view returns the raw synchronized-free pin levels, with a constant 1 above them.

Top module: `pin_change_monitor`

## Requirements
- R1: After reset the accepted levels are all 1, every change flag is 0 and the interrupt request is low.
- R2: The sampler records a pin level only on a clock edge where sampleTick is high. A level is accepted when the current sample equals the previous sample and differs from the accepted level.
- R3: An accepted transition sets the change flag of that pin. This holds for falling (1 to 0) and rising (0 to 1) transitions alike.
- R4: A level that is present for only one tick and then returns is ignored. No flag is set and the accepted level does not change.
- R5: A new level seen at one tick is not yet accepted at that tick. It is accepted at the next tick if it is still present, so the latency is two ticks.
- R6: statusReg carries the accepted levels in bits 7:4 and the change flags in bits 3:0. Bit 4 and bit 0 belong to pin 0.
- R7: A clock edge with rdStrobe high clears all change flags and leaves the accepted levels unchanged.
- R8: A transition accepted on the same edge as a read leaves its flag set after that edge.
- R9: Change flags stay set across any number of ticks until a read.
- R10: irqReq is high exactly when some pin has both its flag and its irqEnable bit set. It follows irqEnable without a clock delay.
- R11: portView is {1'b1, pinsAsync}. It is combinational and unlatched.
- R12: Levels and flags never change on an edge where neither sampleTick nor rdStrobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle slow sampling pulse |
| pinsAsync | input | 4 | Asynchronous monitored pins |
| rdStrobe | input | 1 | One-cycle read of the status byte; clears the flags |
| irqEnable | input | 4 | Per-pin interrupt enable |
| statusReg | output | 8 | {accepted levels, change flags} |
| portView | output | 5 | {1, raw pin levels} |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench targets a set of corner cases, and each one would expose a specific mistake:

- **Latency.** A design that accepted a level on the first tick would show the change one tick early.
- **Single-tick glitch.** A design that compared only against the accepted level would show a flag for the glitch.
- **Read on the same edge as an accepted transition.** A design that gave the clear priority would lose that event.
- **Ticks with no read.** A level-mirroring design would drop a flag once the input returned to its old level.
- **Enable masking.** A registered interrupt would lag by one cycle.

Random pin patterns, ticks, reads and masks are then run against a bench model.

// File: rtl/cos_pkg.sv
package cos_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic sampleNow;
    logic clearFlags;
  } cosStrobes_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] dIn,
  output logic [N-1:0] dOut
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{RST_LVL}};
      else       chain <= {chain[STAGES-2:0], dIn[b]};
    end
    assign dOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cos_ctrl.sv
module cos_ctrl
  import cos_pkg::*;
(
  input  logic        sampleTick,
  input  logic        rdStrobe,
  output cosStrobes_t strobes
);
  always_comb begin
    strobes.sampleNow  = sampleTick;
    strobes.clearFlags = rdStrobe;
  end
endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
#(
  parameter int N = 4,
  parameter logic RST_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  cosStrobes_t  strobes,
  input  logic [N-1:0] syncPins,
  input  logic [N-1:0] irqEnable,
  output logic [N-1:0] levels,
  output logic [N-1:0] flags,
  output logic         irqReq
);
  logic [N-1:0] prevSample;
  logic [N-1:0] confirm;

  // A level is accepted when two consecutive samples agree and differ from the accepted level
  assign confirm = ~(syncPins ^ prevSample) & (syncPins ^ levels);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= {N{RST_LVL}};
      levels     <= {N{RST_LVL}};
      flags      <= '0;
    end else begin
      if (strobes.sampleNow) begin
        prevSample <= syncPins;
        levels     <= levels ^ confirm;
      end
      // A new event wins over a clear on the same edge
      flags <= (strobes.clearFlags ? '0 : flags) |
               (strobes.sampleNow ? confirm : '0);
    end
  end

  assign irqReq = |(flags & irqEnable);
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
  import cos_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic RESET_LEVEL = 1'b1,
  localparam int STATUS_W = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic [NUM_PINS-1:0] pinsAsync,
  input  logic                rdStrobe,
  input  logic [NUM_PINS-1:0] irqEnable,
  output logic [STATUS_W-1:0] statusReg,
  output logic [NUM_PINS:0]   portView,
  output logic                irqReq
);
  cosStrobes_t         strobes;
  logic [NUM_PINS-1:0] syncPins;
  logic [NUM_PINS-1:0] levels;
  logic [NUM_PINS-1:0] flags;

  cos_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES), .RST_LVL(RESET_LEVEL)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(pinsAsync), .dOut(syncPins)
  );

  cos_ctrl u_ctrl (
    .sampleTick(sampleTick), .rdStrobe(rdStrobe), .strobes(strobes)
  );

  cos_datapath #(.N(NUM_PINS), .RST_LVL(RESET_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .syncPins(syncPins),
    .irqEnable(irqEnable), .levels(levels), .flags(flags), .irqReq(irqReq)
  );

  assign statusReg = {levels, flags};
  assign portView  = {1'b1, pinsAsync};
endmodule

// File: rtl/cos_checker.sv
module cos_checker #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           sampleTick,
  input logic           rdStrobe,
  input logic [2*N-1:0] statusReg
);
  logic [N-1:0] lvl;
  logic [N-1:0] flg;
  assign lvl = statusReg[2*N-1:N];
  assign flg = statusReg[N-1:0];

  // R12
  levels_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(lvl));

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> ((flg & $past(flg)) == $past(flg)));

  // R3
  change_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> (((lvl ^ $past(lvl)) & ~flg) == '0));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !sampleTick) |=> (flg == '0));

  // R12
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> ((flg & ~$past(flg)) == '0));
endmodule

bind pin_change_monitor cos_checker #(.N(NUM_PINS)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
  .rdStrobe(rdStrobe), .statusReg(statusReg)
);

// File: tb/sim_pin_change_monitor.sv
module sim_pin_change_monitor;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic [3:0] pinsAsync = 4'hF;
  logic       rdStrobe = 1'b0;
  logic [3:0] irqEnable = 4'h0;
  logic [7:0] statusReg;
  logic [4:0] portView;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] mLvl, mPrev, mFlg;

  always #2 clk = ~clk;

  pin_change_monitor u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .pinsAsync(pinsAsync),
    .rdStrobe(rdStrobe), .irqEnable(irqEnable), .statusReg(statusReg),
    .portView(portView), .irqReq(irqReq)
  );

  function automatic logic [3:0] confirmMask(logic [3:0] p, logic [3:0] prv, logic [3:0] l);
    return ~(p ^ prv) & (p ^ l);
  endfunction

  function automatic logic expIrq(logic [3:0] f, logic [3:0] en);
    return |(f & en);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setPins(logic [3:0] v);
    @(negedge clk);
    pinsAsync = v;
    #1 chk("R11 portView", 32'(portView), 32'({1'b1, v}));
    repeat (3) @(negedge clk);
  endtask

  // One clock edge with optional tick and read; model updated, outputs checked
  task automatic step(bit tk, bit rd, string req);
    logic [3:0] c;
    @(negedge clk);
    sampleTick = tk;
    rdStrobe = rd;
    @(posedge clk);
    c = tk ? confirmMask(pinsAsync, mPrev, mLvl) : 4'h0;
    if (tk) begin
      mPrev = pinsAsync;
      mLvl = mLvl ^ c;
    end
    mFlg = (rd ? 4'h0 : mFlg) | c;
    #1;
    sampleTick = 1'b0;
    rdStrobe = 1'b0;
    chk(req, 32'(statusReg), 32'({mLvl, mFlg}));
    chk("R10 irq", 32'(irqReq), 32'(expIrq(mFlg, irqEnable)));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'hC05E);
    mLvl = 4'hF; mPrev = 4'hF; mFlg = 4'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(statusReg), 32'h F0);
    chk("R1 irq", 32'(irqReq), 32'h0);

    // R5 and R3 falling edge on pin 0
    setPins(4'hE);
    step(1, 0, "R5 first tick not accepted");
    chk("R5 level pin0 still 1", 32'(statusReg[4]), 32'h1);
    step(1, 0, "R3 falling accepted");
    chk("R6 layout", 32'(statusReg), 32'h E1);

    // R7 read clears flags, keeps levels
    chk("R7 pre-read", 32'(statusReg[3:0]), 32'h1);
    step(0, 1, "R7 read clears");
    chk("R7 levels kept", 32'(statusReg[7:4]), 32'hE);

    // R3 rising
    setPins(4'hF);
    step(1, 0, "R5 rising first tick");
    step(1, 0, "R3 rising accepted");
    // R9 sticky across ticks
    repeat (3) step(1, 0, "R9 sticky");
    chk("R9 flag pin0", 32'(statusReg[0]), 32'h1);
    step(0, 1, "R7 read clears");

    // R4 single-tick glitch on pin 1
    setPins(4'hD);
    step(1, 0, "R4 glitch tick");
    setPins(4'hF);
    step(1, 0, "R4 glitch gone");
    step(1, 0, "R4 glitch gone");
    chk("R4 no flag", 32'(statusReg), 32'h F0);

    // R8 confirm on same edge as read
    setPins(4'hB);
    step(1, 0, "R8 first tick");
    step(1, 1, "R8 confirm with read");
    chk("R8 flag kept", 32'(statusReg[2]), 32'h1);

    // R10 masking, combinational
    @(negedge clk); irqEnable = 4'h8;
    #1 chk("R10 masked", 32'(irqReq), 32'h0);
    @(negedge clk); irqEnable = 4'h4;
    #1 chk("R10 enabled", 32'(irqReq), 32'h1);

    // R12 no tick: pins move, state frozen
    setPins(4'h0);
    repeat (10) step(0, 0, "R12 no tick");
    chk("R12 frozen", 32'(statusReg), 32'h B4);
    step(0, 1, "R7 read clears");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 2 == 0) setPins(4'($urandom));
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        irqEnable = 4'($urandom);
      end
      step(($urandom % 3) != 0, ($urandom % 4) == 0, "R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule